// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two descriptors from a translation table in memory. A requester presents a virtual address with a valid/ready handshake, and the walker samples the per-process translation table base at the same moment. The walker then issues one memory read for the first-level descriptor. From that descriptor it forms the second-level table base and issues a second, dependent read. Finally it builds the physical address from the page frame in the second-level descriptor and the untouched page offset of the virtual address.

The address split is fixed at 12/8/12. Virtual bits [31:20] select one of 4096 first-level entries. Bits [19:12] select one of 256 second-level entries. Bits [11:0] are the offset within a 4 KiB page. Each entry is 4 bytes wide. The memory port carries one read at a time: a request pulse with an address, then a response strobe with data after any number of cycles. A descriptor whose two type bits are both zero ends the walk with a fault. The walker reports which level failed and keeps the result on its outputs until the requester acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and mem_req_o, done_o and fault_o are 0.
- R2: The first read address is {ttb[31:14], va[31:20], 2'b00}. The low 14 bits of the table base are ignored, and the table base and the address are both sampled at acceptance.
- R3: The second read address is {l1_desc[31:10], va[19:12], 2'b00}.
- R4: On a successful walk, pa_o = {l2_desc[31:12], va[11:0]} with fault_o = 0. For example, VA 0x01206000 with L1 descriptor 0x053C6381 and L2 descriptor 0x578DBC7F gives PA 0x578DB000.
- R5: A first-level descriptor with bits [1:0] = 2'b00 ends the walk with fault_o = 1, fault_level_o = 0 (0 = first level) and pa_o = 0. No second read is issued.
- R6: A second-level descriptor with bits [1:0] = 2'b00 ends the walk with fault_o = 1, fault_level_o = 1 (1 = second level) and pa_o = 0.
- R7: At most one read is outstanding. mem_req_o is high for exactly one cycle per read and stays low until mem_rvalid_i returns.
- R8: A request is accepted only while req_ready_o is high, and req_ready_o is high only when the walker is idle. A request presented during a walk is ignored and does not change the result.
- R9: While done_o is high and ack_i is low, done_o, pa_o, fault_o and fault_level_o hold their values. One cycle after ack_i, done_o is 0 and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_i | input | 32 | Translation table base (16 KiB aligned) |
| req_valid_i | input | 1 | Translation request valid |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| mem_req_o | output | 1 | One-cycle read request pulse |
| mem_addr_o | output | 32 | Read address |
| mem_rdata_i | input | 32 | Read response data |
| mem_rvalid_i | input | 1 | Read response strobe |
| done_o | output | 1 | Result valid, held until ack_i |
| pa_o | output | 32 | Translated physical address |
| fault_o | output | 1 | Walk aborted on an invalid descriptor |
| fault_level_o | output | 1 | Level that faulted: 0 first, 1 second |
| ack_i | input | 1 | Requester consumes the result |

## Verification
Assertions check several rules on every cycle. Each read pulse lasts a single cycle, and no new pulse is issued while a response is pending. Ready is never raised while a walk or a result is in flight. The result stays frozen until it is acknowledged, and a faulted result carries a zero physical address. Only the bench can show that the read addresses and the composed physical address are right. It does this for random and directed descriptors and response delays, including the worked example, faults at both levels, and ignored requests with a changed table base during a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_L1_REQ,
    W_L1_WAIT,
    W_L2_REQ,
    W_L2_WAIT,
    W_DONE
  } walk_state_e;

  localparam int unsigned DESC_TYPE_W = 2;
endpackage

// File: rtl/pt_desc_check.sv
module pt_desc_check #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] desc_i,
  output logic          ok_o
);
  import pt_walker_pkg::*;
  // type bits all zero marks an unmapped entry
  assign ok_o = |desc_i[DESC_TYPE_W-1:0];
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned AW       = 32,
  parameter int unsigned L1_IDX_W = 12,
  parameter int unsigned L2_IDX_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          cap_l1_i,
  input  logic          cap_pa_i,
  input  logic          sel_l2_i,
  input  logic [AW-1:0] ttb_i,
  input  logic [AW-1:0] va_i,
  input  logic [AW-1:0] rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] pa_o
);
  localparam int unsigned OFF_W   = AW - L1_IDX_W - L2_IDX_W;
  localparam int unsigned TBASE_W = AW - L1_IDX_W - 2;
  localparam int unsigned L2B_W   = AW - L2_IDX_W - 2;
  localparam int unsigned PFN_W   = AW - OFF_W;

  logic [AW-1:0]      va_q;
  logic [TBASE_W-1:0] tbase_q;
  logic [L2B_W-1:0]   l2base_q;
  logic [AW-1:0]      pa_q;
  logic [AW-1:0]      l1_addr, l2_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q     <= '0;
      tbase_q  <= '0;
      l2base_q <= '0;
      pa_q     <= '0;
    end else begin
      if (accept_i) begin
        va_q    <= va_i;
        tbase_q <= ttb_i[AW-1 -: TBASE_W];
        pa_q    <= '0;
      end
      if (cap_l1_i) l2base_q <= rdata_i[AW-1 -: L2B_W];
      if (cap_pa_i) pa_q <= {rdata_i[AW-1 -: PFN_W], va_q[OFF_W-1:0]};
    end
  end

  assign l1_addr    = {tbase_q, va_q[AW-1 -: L1_IDX_W], 2'b00};
  assign l2_addr    = {l2base_q, va_q[OFF_W +: L2_IDX_W], 2'b00};
  assign mem_addr_o = sel_l2_i ? l2_addr : l1_addr;
  assign pa_o       = pa_q;
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_rvalid_i,
  input  logic l1_ok_i,
  input  logic l2_ok_i,
  input  logic ack_i,
  output logic req_ready_o,
  output logic mem_req_o,
  output logic sel_l2_o,
  output logic accept_o,
  output logic cap_l1_o,
  output logic cap_pa_o,
  output logic done_o,
  output logic fault_o,
  output logic fault_level_o
);
  walk_state_e state_q, state_d;
  logic done_q, fault_q, lvl_q;

  assign req_ready_o = (state_q == W_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign mem_req_o   = (state_q == W_L1_REQ) || (state_q == W_L2_REQ);
  assign sel_l2_o    = (state_q == W_L2_REQ) || (state_q == W_L2_WAIT);
  assign cap_l1_o    = (state_q == W_L1_WAIT) && mem_rvalid_i && l1_ok_i;
  assign cap_pa_o    = (state_q == W_L2_WAIT) && mem_rvalid_i && l2_ok_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      W_IDLE:    if (req_valid_i) state_d = W_L1_REQ;
      W_L1_REQ:  state_d = W_L1_WAIT;
      W_L1_WAIT: if (mem_rvalid_i) state_d = l1_ok_i ? W_L2_REQ : W_DONE;
      W_L2_REQ:  state_d = W_L2_WAIT;
      W_L2_WAIT: if (mem_rvalid_i) state_d = W_DONE;
      W_DONE:    if (ack_i) state_d = W_IDLE;
      default:   state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        fault_q <= 1'b0;
        lvl_q   <= 1'b0;
      end
      if (state_q == W_L1_WAIT && mem_rvalid_i && !l1_ok_i) begin
        done_q  <= 1'b1;
        fault_q <= 1'b1;
        lvl_q   <= 1'b0;
      end
      if (state_q == W_L2_WAIT && mem_rvalid_i) begin
        done_q  <= 1'b1;
        fault_q <= !l2_ok_i;
        lvl_q   <= !l2_ok_i;
      end
      if (state_q == W_DONE && ack_i) done_q <= 1'b0;
    end
  end

  assign done_o        = done_q;
  assign fault_o       = fault_q;
  assign fault_level_o = lvl_q;

  p_req_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_no_req_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && sel_l2_o && !mem_rvalid_i) |=> !mem_req_o);

  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!done_o && !mem_req_o));

  p_hold_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> (done_o && $stable(fault_o) && $stable(fault_level_o)));

  p_ack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ack_i) |=> (!done_o && req_ready_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned AW       = 32,
  parameter int unsigned L1_IDX_W = 12,
  parameter int unsigned L2_IDX_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ttb_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_va_i,
  output logic          req_ready_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i,
  output logic          done_o,
  output logic [AW-1:0] pa_o,
  output logic          fault_o,
  output logic          fault_level_o,
  input  logic          ack_i
);
  localparam int unsigned N_LVL = 2;

  logic [N_LVL-1:0] lvl_ok;
  logic accept, cap_l1, cap_pa, sel_l2;

  for (genvar g = 0; g < N_LVL; g++) begin : g_chk
    pt_desc_check #(.AW(AW)) u_chk (
      .desc_i (mem_rdata_i),
      .ok_o   (lvl_ok[g])
    );
  end

  pt_walk_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .mem_rvalid_i  (mem_rvalid_i),
    .l1_ok_i       (lvl_ok[0]),
    .l2_ok_i       (lvl_ok[1]),
    .ack_i         (ack_i),
    .req_ready_o   (req_ready_o),
    .mem_req_o     (mem_req_o),
    .sel_l2_o      (sel_l2),
    .accept_o      (accept),
    .cap_l1_o      (cap_l1),
    .cap_pa_o      (cap_pa),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .fault_level_o (fault_level_o)
  );

  pt_addr_gen #(
    .AW       (AW),
    .L1_IDX_W (L1_IDX_W),
    .L2_IDX_W (L2_IDX_W)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .cap_l1_i   (cap_l1),
    .cap_pa_i   (cap_pa),
    .sel_l2_i   (sel_l2),
    .ttb_i      (ttb_i),
    .va_i       (req_va_i),
    .rdata_i    (mem_rdata_i),
    .mem_addr_o (mem_addr_o),
    .pa_o       (pa_o)
  );

  p_fault_pa_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0));

  p_hold_pa_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> $stable(pa_o));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ttb = '0, va = '0, rdata = '0;
  logic req_valid = 1'b0, rvalid = 1'b0, ack = 1'b0;
  logic req_ready, mem_req, done, fault, flvl;
  logic [31:0] mem_addr, pa;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ttb_i(ttb), .req_valid_i(req_valid),
    .req_va_i(va), .req_ready_o(req_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(rdata), .mem_rvalid_i(rvalid),
    .done_o(done), .pa_o(pa), .fault_o(fault), .fault_level_o(flvl), .ack_i(ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] t, input logic [31:0] v);
    return {t[31:14], v[31:20], 2'b00};
  endfunction
  function automatic logic [31:0] l2_addr(input logic [31:0] d, input logic [31:0] v);
    return {d[31:10], v[19:12], 2'b00};
  endfunction

  // respond after dly cycles; poke drives an unrelated request meanwhile
  task automatic respond(input logic [31:0] data, input int dly, input bit poke);
    for (int i = 0; i < dly; i++) begin
      if (poke) begin
        req_valid = 1'b1;
        va = $urandom;
        ttb = $urandom;
      end
      @(negedge clk);
      chk(!mem_req, "R7", {31'b0, mem_req}, 32'h0);
      if (poke) chk(!req_ready, "R8", {31'b0, req_ready}, 32'h0);
    end
    req_valid = 1'b0;
    rvalid = 1'b1;
    rdata = data;
    @(negedge clk);
    rvalid = 1'b0;
    rdata = $urandom;
  endtask

  task automatic walk(input logic [31:0] v, input logic [31:0] t,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input int dly, input bit poke);
    bit f1, f2;
    logic [31:0] exp_pa;
    f1 = (d1[1:0] == 2'b00);
    f2 = !f1 && (d2[1:0] == 2'b00);
    exp_pa = (f1 || f2) ? 32'h0 : {d2[31:12], v[11:0]};
    @(negedge clk);
    chk(req_ready, "R8", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; va = v; ttb = t;
    @(negedge clk);
    req_valid = 1'b0; va = $urandom; ttb = $urandom;
    chk(mem_req, "R2", {31'b0, mem_req}, 32'h1);
    chk(mem_addr == l1_addr(t, v), "R2", mem_addr, l1_addr(t, v));
    @(negedge clk);
    chk(!mem_req, "R7", {31'b0, mem_req}, 32'h0);
    respond(d1, dly, poke);
    if (f1) begin
      chk(!mem_req, "R5", {31'b0, mem_req}, 32'h0);
    end else begin
      chk(mem_req, "R3", {31'b0, mem_req}, 32'h1);
      chk(mem_addr == l2_addr(d1, v), "R3", mem_addr, l2_addr(d1, v));
      @(negedge clk);
      respond(d2, dly, poke);
    end
    chk(done, "R4", {31'b0, done}, 32'h1);
    if (f1) begin
      chk(fault && !flvl, "R5", {30'b0, fault, flvl}, 32'h2);
      chk(pa == 32'h0, "R5", pa, 32'h0);
    end else if (f2) begin
      chk(fault && flvl, "R6", {30'b0, fault, flvl}, 32'h3);
      chk(pa == 32'h0, "R6", pa, 32'h0);
    end else begin
      chk(!fault, "R4", {31'b0, fault}, 32'h0);
      chk(pa == exp_pa, "R4", pa, exp_pa);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done && pa == exp_pa && fault == (f1 || f2), "R9", pa, exp_pa);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(!done && req_ready, "R9", {30'b0, done, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done && !fault, "R1",
        {28'b0, req_ready, mem_req, done, fault}, 32'h8);
    rst_n = 1'b1;
    // worked example, unaligned base bits ignored
    walk(32'h0120_6000, 32'h0D7E_3380, 32'h053C_6381, 32'h578D_BC7F, 0, 1'b0);
    walk(32'h0120_6ABC, 32'h4000_0000, 32'h053C_6381, 32'h578D_BC7F, 2, 1'b1);
    // faults at each level
    walk(32'hFFFF_FFFF, 32'h8000_3FFF, 32'hABCD_EF00, 32'h1111_1111, 1, 1'b0);
    walk(32'h0000_0000, 32'h0000_C000, 32'h1234_5601, 32'h9999_9004, 3, 1'b1);
    walk(32'hC000_0FFF, 32'hFFFF_C000, 32'hFFFF_FFFE, 32'hFFFF_F003, 0, 1'b0);
    for (int n = 0; n < 60; n++) begin
      walk($urandom, $urandom, $urandom, $urandom, $urandom_range(0, 4), n[0]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule